// File: doc/BRIEF.md
# Receive Signaling Realignment and Override Unit

This block sits in the receive data path downstream of an elastic store and rewrites signaling bit positions in the outgoing time-slot stream. The stream arrives one time slot per beat, and each beat carries a slot index. Signaling is realigned to a multiframe sync pulse that the user supplies, not to the line framing. The block counts frames itself from that pulse. For channels whose enable bit is set, it overwrites the signaling positions with buffered signaling words held outside the block.

In T1 mode the block replaces the robbed bit, which is the channel LSB, in frames 6 and 12 of a 12-frame multiframe, or in frames 6, 12, 18 and 24 of a 24-frame multiframe. The line's own robbed-bit signaling stays where the line framing put it, so the output carries both copies. A second per-channel mask, separate from the first, forces the robbed bit of the selected channels to one. In E1 mode the block rebuilds time slot 16 of frames 1 to 15 from the buffered four-bit words, two channels per frame. Reinsertion is blocked when the elastic store is off, and it is also blocked for E1 on a 1.544 MHz backplane.

Top module: `sri_sig_reinsert`

## Requirements
- R1: Each input beat appears on the output exactly one clock later with `out_valid` set. Any bit that no other requirement selects passes through unchanged.
- R2: A beat at slot 0 with `in_mfsync` high starts a multiframe (frame 1 in T1, frame 0 in E1), and every later slot-0 beat advances the frame, wrapping at 12 (T1, `cfg_esf`=0), 24 (T1, `cfg_esf`=1) or 16 (E1). A sync pulse in mid-multiframe restarts the count. Until the first sync pulse nothing is modified.
- R3: In T1, for slot s < 24 with `reins_mask[s]` set, in frame 6k the output LSB takes bit 4-k of signaling word s. Frame 6 takes A (bit 3), frame 12 takes B (bit 2), frame 18 takes C (bit 1) and frame 24 takes D (bit 0). Bits 7..1 always pass unchanged in T1.
- R4: In E1, at slot 16 of frame f (1..15), bits 7..4 take signaling word f if `reins_mask[f]` is set, and bits 3..0 take word f+16 if `reins_mask[f+16]` is set. Slot 16 of frame 0 and every other slot pass unchanged.
- R5: Reinsertion happens only when `cfg_es_en`=1, and in E1 only when `cfg_bp_2048`=1. Otherwise reinsertion has no effect on the output.
- R6: In T1, in frames that are a multiple of 6, for slot s < 24 with `force_mask[s]` set, the output LSB is 1, whatever `cfg_es_en` and `cfg_bp_2048` are.
- R7: When forcing and reinsertion both select the same channel and frame, forcing wins and the LSB is 1.
- R8: In E1 mode `force_mask` has no effect on the output.
- R9: In T1, slots 24 to 31 (present on a 2.048 MHz backplane) pass unchanged.
- R10: During and right after reset, `out_valid` and `out_data` are 0 and the frame alignment is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 8 | Time-slot byte |
| in_slot | input | 5 | Time-slot index of the beat |
| in_mfsync | input | 1 | User multiframe sync, sampled with slot 0 |
| cfg_e1 | input | 1 | 1 = E1, 0 = T1 |
| cfg_esf | input | 1 | T1 only: 1 = 24-frame multiframe, 0 = 12-frame |
| cfg_es_en | input | 1 | Elastic store enabled |
| cfg_bp_2048 | input | 1 | 1 = 2.048 MHz backplane, 0 = 1.544 MHz |
| reins_mask | input | 32 | Per-slot reinsertion enable |
| force_mask | input | 24 | T1 per-channel force-to-one enable |
| sig_words | input | 128 | Buffered signaling, word k at bits 4k+3..4k, A is the MSB |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Rewritten time-slot byte |

## Verification
Forcing and reinsertion can hit the same beat: a T1 channel in a frame that is a multiple of 6. The bench provokes this by giving the two masks overlapping bits in both multiframe lengths, and it also runs with the elastic store off so that forcing acts alone. A behavioural model counts frames from the sync pulses it drives and predicts each byte. It tags the beats where both functions apply and expects an LSB of 1 there, whatever the signaling word holds.

// File: rtl/sri_pkg.sv
package sri_pkg;
   localparam int T1_D4_FRAMES  = 12;
   localparam int T1_ESF_FRAMES = 24;
   localparam int E1_FRAMES     = 16;
   localparam int ROB_PERIOD    = 6;
   localparam int ROB_SLOTS     = 4;
   localparam int E1_SIG_TS     = 16;
   localparam int ROB_BIT       = 0;

   typedef struct packed {
      logic e1;
      logic esf;
      logic es_en;
      logic bp_2048;
   } sri_cfg_t;

   function automatic logic reins_allowed(input sri_cfg_t c);
      return c.es_en && (!c.e1 || c.bp_2048);
   endfunction
endpackage

// File: rtl/sri_mf_tracker.sv
module sri_mf_tracker
   import sri_pkg::*;
#(
   parameter int FW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          beat_first,
   input  logic          sync,
   input  logic          cfg_e1,
   input  logic          cfg_esf,
   output logic [FW-1:0] frame_cur,
   output logic          aligned_cur,
   output logic          robbed,
   output logic [1:0]    rob_idx
);
   localparam int FMAX = T1_ESF_FRAMES;

   if ((1 << FW) <= FMAX) begin : g_chk_fw
      $error("sri_mf_tracker: FW too narrow for frame count");
   end

   logic [FW-1:0] frame_q;
   logic          aligned_q;
   logic [FW-1:0] first_f;
   logic [FW-1:0] last_f;
   logic          hit;

   always_comb begin
      first_f = cfg_e1 ? '0 : FW'(1);
      if (cfg_e1)       last_f = FW'(E1_FRAMES - 1);
      else if (cfg_esf) last_f = FW'(T1_ESF_FRAMES);
      else              last_f = FW'(T1_D4_FRAMES);
   end

   always_comb begin
      frame_cur   = frame_q;
      aligned_cur = aligned_q;
      if (beat_first) begin
         if (sync) begin
            frame_cur   = first_f;
            aligned_cur = 1'b1;
         end else if (frame_q >= last_f) begin
            frame_cur = first_f;
         end else begin
            frame_cur = frame_q + 1'b1;
         end
      end
   end

   always_comb begin
      hit     = 1'b0;
      rob_idx = '0;
      for (int k = 1; k <= ROB_SLOTS; k++) begin
         if (frame_cur == FW'(k * ROB_PERIOD)) begin
            hit     = 1'b1;
            rob_idx = 2'(k - 1);
         end
      end
      robbed = hit && !cfg_e1 && aligned_cur;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q   <= '0;
         aligned_q <= 1'b0;
      end else begin
         frame_q   <= frame_cur;
         aligned_q <= aligned_cur;
      end
   end

   p_frame_bound_r2 : assert property (@(posedge clk) disable iff (rst)
      aligned_q |-> (frame_q <= last_f));

   p_sync_restart_r2 : assert property (@(posedge clk) disable iff (rst)
      (beat_first && sync) |=> (aligned_q && frame_q == $past(first_f)));
endmodule

// File: rtl/sri_t1_lane.sv
module sri_t1_lane
   import sri_pkg::*;
#(
   parameter int DW        = 8,
   parameter int SIGW      = 4,
   parameter int N_SLOT    = 32,
   parameter int N_T1      = 24,
   parameter int SW        = 5,
   parameter bit HAS_FORCE = 1'b1
) (
   input  logic [SW-1:0]          slot,
   input  logic [DW-1:0]          data,
   input  logic [N_SLOT*SIGW-1:0] sig_words,
   input  logic [N_SLOT-1:0]      reins_mask,
   input  logic [N_T1-1:0]        force_mask,
   input  logic                   robbed,
   input  logic [1:0]             rob_idx,
   input  logic                   allow,
   output logic [DW-1:0]          data_out,
   output logic                   force_hit
);
   logic            chan_ok;
   logic [SIGW-1:0] word;
   logic            sig_bit;
   logic            rein_hit;

   always_comb begin
      chan_ok  = 32'(slot) < N_T1;
      word     = sig_words[int'(slot) * SIGW +: SIGW];
      sig_bit  = word[SIGW - 1 - int'(rob_idx)];
      rein_hit = allow && robbed && chan_ok && reins_mask[slot];
   end

   if (HAS_FORCE) begin : g_force
      logic [N_SLOT-1:0] fm_ext;
      assign fm_ext    = N_SLOT'(force_mask);
      assign force_hit = robbed && chan_ok && fm_ext[slot];
   end else begin : g_noforce
      assign force_hit = 1'b0;
   end

   always_comb begin
      data_out = data;
      if (force_hit)     data_out[ROB_BIT] = 1'b1;
      else if (rein_hit) data_out[ROB_BIT] = sig_bit;
   end
endmodule

// File: rtl/sri_e1_lane.sv
module sri_e1_lane
   import sri_pkg::*;
#(
   parameter int DW     = 8,
   parameter int SIGW   = 4,
   parameter int N_SLOT = 32,
   parameter int SW     = 5,
   parameter int FW     = 5
) (
   input  logic [SW-1:0]          slot,
   input  logic [FW-1:0]          frame,
   input  logic                   aligned,
   input  logic [DW-1:0]          data,
   input  logic [N_SLOT*SIGW-1:0] sig_words,
   input  logic [N_SLOT-1:0]      reins_mask,
   input  logic                   allow,
   output logic [DW-1:0]          data_out
);
   localparam int HALF = N_SLOT / 2;

   logic            hit;
   int unsigned     hi_idx;
   int unsigned     lo_idx;
   logic [SIGW-1:0] hi_word;
   logic [SIGW-1:0] lo_word;

   always_comb begin
      hi_idx  = 32'(frame) & (N_SLOT - 1);
      lo_idx  = (hi_idx + HALF) & (N_SLOT - 1);
      hi_word = sig_words[hi_idx * SIGW +: SIGW];
      lo_word = sig_words[lo_idx * SIGW +: SIGW];
      hit     = allow && aligned && (slot == SW'(E1_SIG_TS)) && (frame != '0);
   end

   always_comb begin
      data_out = data;
      if (hit) begin
         if (reins_mask[hi_idx]) data_out[DW-1 -: SIGW] = hi_word;
         if (reins_mask[lo_idx]) data_out[SIGW-1:0]     = lo_word;
      end
   end
endmodule

// File: rtl/sri_sig_reinsert.sv
module sri_sig_reinsert
   import sri_pkg::*;
#(
   parameter int DW        = 8,
   parameter int SIGW      = 4,
   parameter int N_SLOT    = 32,
   parameter int N_T1      = 24,
   parameter int FW        = 5,
   parameter bit HAS_E1    = 1'b1,
   parameter bit HAS_FORCE = 1'b1,
   localparam int SW       = $clog2(N_SLOT)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [DW-1:0]          in_data,
   input  logic [SW-1:0]          in_slot,
   input  logic                   in_mfsync,
   input  logic                   cfg_e1,
   input  logic                   cfg_esf,
   input  logic                   cfg_es_en,
   input  logic                   cfg_bp_2048,
   input  logic [N_SLOT-1:0]      reins_mask,
   input  logic [N_T1-1:0]        force_mask,
   input  logic [N_SLOT*SIGW-1:0] sig_words,
   output logic                   out_valid,
   output logic [DW-1:0]          out_data
);
   if (DW != 2 * SIGW) begin : g_chk_dw
      $error("sri_sig_reinsert: DW must hold two signaling words");
   end
   if (N_SLOT != (1 << SW) || N_SLOT < 2 * E1_FRAMES) begin : g_chk_slot
      $error("sri_sig_reinsert: N_SLOT must be a power of two of at least 32");
   end
   if (N_T1 > N_SLOT || N_T1 < 1) begin : g_chk_t1
      $error("sri_sig_reinsert: N_T1 out of range");
   end
   if (SIGW < ROB_SLOTS) begin : g_chk_sigw
      $error("sri_sig_reinsert: SIGW must cover four signaling bits");
   end

   sri_cfg_t      cfg;
   logic          allow;
   logic          beat_first;
   logic [FW-1:0] frame_cur;
   logic          aligned_cur;
   logic          robbed;
   logic [1:0]    rob_idx;
   logic [DW-1:0] t1_out;
   logic [DW-1:0] e1_out;
   logic [DW-1:0] lane_out;
   logic          t1_force_hit;

   always_comb begin
      cfg        = '{e1: cfg_e1, esf: cfg_esf, es_en: cfg_es_en, bp_2048: cfg_bp_2048};
      allow      = reins_allowed(cfg);
      beat_first = in_valid && (in_slot == '0);
   end

   sri_mf_tracker #(.FW(FW)) i_trk (
      .clk        (clk),
      .rst        (rst),
      .beat_first (beat_first),
      .sync       (in_mfsync),
      .cfg_e1     (cfg.e1),
      .cfg_esf    (cfg.esf),
      .frame_cur  (frame_cur),
      .aligned_cur(aligned_cur),
      .robbed     (robbed),
      .rob_idx    (rob_idx)
   );

   sri_t1_lane #(
      .DW(DW), .SIGW(SIGW), .N_SLOT(N_SLOT), .N_T1(N_T1), .SW(SW), .HAS_FORCE(HAS_FORCE)
   ) i_t1 (
      .slot      (in_slot),
      .data      (in_data),
      .sig_words (sig_words),
      .reins_mask(reins_mask),
      .force_mask(force_mask),
      .robbed    (robbed),
      .rob_idx   (rob_idx),
      .allow     (allow),
      .data_out  (t1_out),
      .force_hit (t1_force_hit)
   );

   if (HAS_E1) begin : g_e1
      sri_e1_lane #(
         .DW(DW), .SIGW(SIGW), .N_SLOT(N_SLOT), .SW(SW), .FW(FW)
      ) i_e1 (
         .slot      (in_slot),
         .frame     (frame_cur),
         .aligned   (aligned_cur),
         .data      (in_data),
         .sig_words (sig_words),
         .reins_mask(reins_mask),
         .allow     (allow),
         .data_out  (e1_out)
      );
   end else begin : g_no_e1
      assign e1_out = in_data;
   end

   assign lane_out = cfg.e1 ? e1_out : t1_out;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= lane_out;
      end
   end

   p_latency_r1 : assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

   p_t1_upper_r3 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && !cfg_e1) |->
         (out_data[DW-1:1] == $past(in_data[DW-1:1])));

   p_force_wins_r7 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid && t1_force_hit)) |-> out_data[ROB_BIT]);

   p_gate_e1_r5 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && cfg_e1 && !$past(allow)) |->
         (out_data == $past(in_data)));

   p_e1_other_slot_r4 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && cfg_e1 && $past(in_slot) != SW'(E1_SIG_TS)) |->
         (out_data == $past(in_data)));

   p_reset_r10 : assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/test_sri_sig_reinsert.sv
module test_sri_sig_reinsert;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [7:0]   in_data = '0;
   logic [4:0]   in_slot = '0;
   logic         in_mfsync = 1'b0;
   logic         cfg_e1 = 1'b0, cfg_esf = 1'b0, cfg_es_en = 1'b1, cfg_bp_2048 = 1'b1;
   logic [31:0]  reins_mask = '0;
   logic [23:0]  force_mask = '0;
   logic [127:0] sig_words;
   logic         out_valid;
   logic [7:0]   out_data;

   logic [3:0]   sig [32];
   int           total = 0;
   int           bad = 0;
   bit           done = 1'b0;

   int           m_fr;
   bit           m_al;
   bit           pend;
   bit           exp_v;
   logic [7:0]   exp_d;
   string        exp_tag;

   always #2.5 clk = ~clk;

   always_comb
      for (int k = 0; k < 32; k++) sig_words[k*4 +: 4] = sig[k];

   sri_sig_reinsert i_sri_sig_reinsert (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_slot(in_slot),
      .in_mfsync(in_mfsync), .cfg_e1(cfg_e1), .cfg_esf(cfg_esf), .cfg_es_en(cfg_es_en),
      .cfg_bp_2048(cfg_bp_2048), .reins_mask(reins_mask), .force_mask(force_mask),
      .sig_words(sig_words), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Behavioural reference: frame counting from sync (R2) and per-beat rewrite.
   task automatic model(input bit v, input int s, input logic [7:0] d, input bit sy);
      int first, last, k;
      bit allow, rein, frc;
      exp_v = v; exp_d = d; exp_tag = "R1";
      if (!v) return;
      first = cfg_e1 ? 0 : 1;
      last  = cfg_e1 ? 15 : (cfg_esf ? 24 : 12);
      if (s == 0) begin
         if (sy) begin m_al = 1; m_fr = first; end
         else m_fr = (m_fr >= last) ? first : m_fr + 1;
      end
      allow = cfg_es_en && (!cfg_e1 || cfg_bp_2048);
      if (!m_al) begin
         exp_tag = "R2";
      end else if (!cfg_e1) begin
         if (s >= 24) exp_tag = "R9";
         else if (m_fr % 6 == 0) begin
            k = m_fr / 6;
            rein = allow && reins_mask[s];
            frc = force_mask[s];
            if (frc) begin exp_d[0] = 1'b1; exp_tag = rein ? "R7" : "R6"; end
            else if (rein) begin exp_d[0] = sig[s][4-k]; exp_tag = "R3"; end
            else if (reins_mask[s]) exp_tag = "R5";
         end
      end else begin
         if (s == 16 && m_fr != 0) begin
            if (allow) begin
               if (reins_mask[m_fr]) exp_d[7:4] = sig[m_fr];
               if (reins_mask[m_fr+16]) exp_d[3:0] = sig[m_fr+16];
               exp_tag = "R4";
            end else exp_tag = "R5";
         end else if (s < 24 && force_mask[s]) exp_tag = "R8";
      end
   endtask

   task automatic compare_pending();
      if (pend) begin
         check({exp_tag, " valid"}, {7'b0, out_valid}, {7'b0, exp_v});
         if (exp_v) check(exp_tag, out_data, exp_d);
      end
   endtask

   task automatic beat(input bit v, input int s, input logic [7:0] d, input bit sy);
      @(negedge clk);
      compare_pending();
      in_valid = v; in_slot = 5'(s); in_data = d; in_mfsync = sy;
      model(v, s, d, sy);
      pend = 1'b1;
   endtask

   task automatic frames(input int nf, input int nslot, input int sync_frame);
      for (int f = 0; f < nf; f++)
         for (int s = 0; s < nslot; s++) begin
            beat(1'b1, s, 8'($urandom), (f == sync_frame) && (s == 0));
            if ($urandom_range(0, 15) == 0) beat(1'b0, 0, 8'h00, 1'b0);
         end
   endtask

   task automatic do_reset();
      @(negedge clk);
      compare_pending();
      pend = 1'b0;
      rst = 1'b1; in_valid = 1'b0; in_mfsync = 1'b0;
      m_fr = 0; m_al = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R10 out_valid", {7'b0, out_valid}, 8'h00);
      check("R10 out_data", out_data, 8'h00);
   endtask

   task automatic new_sig();
      for (int k = 0; k < 32; k++) sig[k] = 4'($urandom);
   endtask

   initial begin
      new_sig();
      pend = 1'b0; m_fr = 0; m_al = 0;
      repeat (4) @(negedge clk);
      check("R10 out_valid", {7'b0, out_valid}, 8'h00);
      check("R10 out_data", out_data, 8'h00);

      // R3 R6 R7 T1 12-frame, overlapping masks, pre-sync beats (R2), resync (R2)
      cfg_e1 = 0; cfg_esf = 0; cfg_es_en = 1; cfg_bp_2048 = 0;
      reins_mask = 32'h00F0_F3A5; force_mask = 24'h0F_0303;
      do_reset();
      frames(3, 24, 1);
      frames(30, 24, 7);

      // T1 24-frame on 2.048 backplane: slots 24..31 (R9)
      cfg_esf = 1; cfg_bp_2048 = 1; new_sig();
      reins_mask = 32'hFFFF_FFFF; force_mask = 24'h80_1001;
      do_reset();
      frames(75, 32, 0);

      // T1 with elastic store off: reinsertion gated (R5), force still acts (R6)
      cfg_es_en = 0; cfg_esf = 0; new_sig();
      reins_mask = 32'h00FF_FFFF; force_mask = 24'h00_F00F;
      do_reset();
      frames(26, 24, 0);

      // E1 on 2.048 backplane (R4), force mask set and ignored (R8)
      cfg_e1 = 1; cfg_es_en = 1; cfg_bp_2048 = 1; new_sig();
      reins_mask = 32'hA5F0_0FFE; force_mask = 24'hFF_FFFF;
      do_reset();
      frames(40, 32, 2);

      // E1 on 1.544 backplane: reinsertion blocked (R5)
      cfg_bp_2048 = 0; reins_mask = 32'hFFFF_FFFF; new_sig();
      do_reset();
      frames(20, 32, 0);

      @(negedge clk);
      compare_pending();
      pend = 1'b0;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule